// File: doc/BRIEF.md
# Vectored Interrupt Controller with In-Service Tracking

The block gathers 32 peripheral event lines into a pending register, filters them through a software mask and drives one interrupt request line toward a processor. When the processor runs an acknowledge handshake, the block returns an 8-bit vector for the highest-ranked eligible source. In the same clock edge it moves that source from pending to in-service. The interrupt service routine later retires the source by writing a one to its in-service bit.

A source with its mask bit cleared still records its event. It raises the request once software sets the mask bit again. Priority is fixed by bit position, and bit 31 ranks highest. A request is only raised for a source that outranks every source currently in service, so only higher-priority handlers can nest. If an acknowledge arrives while nothing is eligible, the block answers with an error vector. No mask setting can suppress it.

Registers sit behind a small synchronous port. Writes take effect at the clock edge, and reads return data combinationally from the selected register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An event on `src_i[n]` sets pending bit n at the next clock edge whatever the value of mask bit n. A pending bit stays set until its source is acknowledged.
- R2: `irq_o` is high only when some pending bit has its mask bit set. Clearing that mask bit drops `irq_o` in the cycle after the write. Setting it again while the bit is still pending raises `irq_o` again.
- R3: Among unmasked pending sources, the highest bit index wins. This covers index 31 and index 0.
- R4: `vec_valid_o` is high for exactly the cycle after each `ack_i` cycle. In that cycle `vec_o` = {base[1:0], 1'b0, index[4:0]} of the winning source.
- R5: At the acknowledge edge the winner's pending bit clears and its in-service bit sets. A new event on the same source in that cycle leaves the pending bit set.
- R6: Writing to the in-service register clears each bit written as one. Bits written as zero keep their value.
- R7: After reset the mask, pending, in-service and base registers read zero, and `irq_o` and `vec_valid_o` are low.
- R8: An acknowledge while `irq_o` is low returns the error vector {base[1:0], 1'b1, 5'b00000}. It changes no pending or in-service bit, and every mask setting still produces it.
- R9: `irq_o` is high only if the best unmasked pending index is strictly above the highest in-service index. When no bit is in service, any unmasked pending source qualifies.
- R10: Address map on `addr_i`: 0 is the mask (read-write), 1 is pending (read-only, writes ignored), 2 is in-service (write-one-to-clear) and 3 is the base (read-write, bits 1:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Per-source event lines, sampled every cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request toward the processor |
| ack_i | input | 1 | Interrupt acknowledge, one cycle per handshake |
| vec_o | output | 8 | Vector returned for the acknowledge |
| vec_valid_o | output | 1 | Vector valid, cycle after acknowledge |

## Verification
The bench holds a source pending while its mask bit toggles. A design that gated latching with the mask would lose the event, and one that registered the mask late would keep the request after masking. The bench acknowledges with the mask fully cleared and expects the error vector with no state change. A design that served a masked source or set an in-service bit there would differ. The bench fires a fresh event on a source in the very cycle it is acknowledged, which exposes a clear-after-set ordering mistake. Nested acknowledges with partial write-one-to-clear retirement expose an in-service comparison that is off by one, or clears written-zero bits.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ISR  = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int N      = 32,
  parameter int BASE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      src_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      clr_pend_i,
  input  logic [N-1:0]      set_isr_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pend_o,
  output logic [N-1:0]      isr_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N-1:0]      rdata_o
);
  reg_sel_e    sel;
  logic [N-1:0] isr_w1c;

  assign sel     = reg_sel_e'(addr_i);
  assign isr_w1c = (wr_en_i && sel == SEL_ISR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      pend_o <= '0;
      isr_o  <= '0;
      base_o <= '0;
    end else begin
      // event in the acknowledge cycle wins over the clear
      pend_o <= (pend_o & ~clr_pend_i) | src_i;
      // set from acknowledge wins over a same-cycle clear
      isr_o  <= (isr_o & ~isr_w1c) | set_isr_i;
      if (wr_en_i && sel == SEL_MASK) mask_o <= wdata_i;
      if (wr_en_i && sel == SEL_BASE) base_o <= wdata_i[BASE_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rdata_o = mask_o;
      SEL_PEND: rdata_o = pend_o;
      SEL_ISR:  rdata_o = isr_o;
      default:  rdata_o = N'(base_o);
    endcase
  end
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  output logic          eligible_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N-1:0]  win_oh_o
);
  logic          p_any, s_any;
  logic [IW-1:0] p_idx, s_idx;

  ivc_prio_enc #(.N(N), .IW(IW)) u_pend_enc (
    .req_i (pend_i & mask_i),
    .any_o (p_any),
    .idx_o (p_idx)
  );

  ivc_prio_enc #(.N(N), .IW(IW)) u_isr_enc (
    .req_i (isr_i),
    .any_o (s_any),
    .idx_o (s_idx)
  );

  assign eligible_o = p_any && (!s_any || p_idx > s_idx);
  assign win_idx_o  = p_idx;
  assign win_oh_o   = N'(1) << p_idx;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_o,
  input  logic             ack_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int BASE_W = VEC_W - IDX_W - 1;

  logic [N_SRC-1:0]  mask_q, pend_q, isr_q, win_oh, grant_oh;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  win_idx;
  logic              eligible, grant;

  assign grant    = ack_i && eligible;
  assign grant_oh = grant ? win_oh : '0;

  ivc_regs #(.N(N_SRC), .BASE_W(BASE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .clr_pend_i (grant_oh),
    .set_isr_i  (grant_oh),
    .mask_o     (mask_q),
    .pend_o     (pend_q),
    .isr_o      (isr_q),
    .base_o     (base_q),
    .rdata_o    (rdata_o)
  );

  ivc_arb #(.N(N_SRC), .IW(IDX_W)) u_arb (
    .mask_i     (mask_q),
    .pend_i     (pend_q),
    .isr_i      (isr_q),
    .eligible_o (eligible),
    .win_idx_o  (win_idx),
    .win_oh_o   (win_oh)
  );

  assign irq_o = eligible;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= grant ? {base_q, 1'b0, win_idx} : {base_q, 1'b1, IDX_W'(0)};
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] isr_q
);
  localparam int IDX_W = $clog2(N_SRC);

  p_event_latched_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

  p_irq_needs_unmasked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_q & mask_q) != '0));

  p_valid_follows_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);

  p_no_spurious_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o);

  p_isr_marked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> isr_q[vec_o[IDX_W-1:0]] && !vec_o[IDX_W]);

  p_error_vector_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (vec_o[IDX_W] && vec_o[IDX_W-1:0] == '0));

  p_error_keeps_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> ((isr_q & ~$past(isr_q)) == '0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .isr_q       (isr_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        ack_i = 1'b0;
  logic [7:0]  vec_o;
  logic        vec_valid_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk_i, .rst_ni, .src_i, .wr_en_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .ack_i, .vec_o, .vec_valid_o
  );

  function automatic logic [7:0] mk_vec(input logic [1:0] base, input logic err, input int idx);
    return {base, err, 5'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk_i);
    src_i = s;
    @(negedge clk_i);
    src_i = '0;
  endtask

  // driver: push expected vector, then acknowledge
  task automatic ack(input logic [7:0] exp, input string req, input logic [31:0] s = '0);
    @(negedge clk_i);
    exp_q.push_back(exp); tag_q.push_back(req);
    ack_i = 1'b1; src_i = s;
    @(negedge clk_i);
    ack_i = 1'b0; src_i = '0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (vec_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: unexpected vector %h expected none", vec_o);
      end else begin
        check(tag_q.pop_front(), 32'(vec_o), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R7 reset state
    check("R7 irq", 32'(irq_o), 0);
    check("R7 valid", 32'(vec_valid_o), 0);
    rd(2'd0, d); check("R7 mask", d, 0);
    rd(2'd1, d); check("R7 pend", d, 0);
    rd(2'd2, d); check("R7 isr", d, 0);
    rd(2'd3, d); check("R7 base", d, 0);
    rst_ni = 1'b1;

    // R1 masked event still latches
    pulse(32'h20);
    rd(2'd1, d); check("R1 pend", d, 32'h20);
    check("R2 masked irq", 32'(irq_o), 0);
    wr(2'd0, 32'h20); check("R2 unmask", 32'(irq_o), 1);
    wr(2'd0, 32'h0);  check("R2 remask", 32'(irq_o), 0);
    wr(2'd0, 32'h20); check("R2 restore", 32'(irq_o), 1);

    // R10 pending is read-only, base readback
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R10 pend ro", d, 32'h20);
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, d); check("R10 base", d, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);

    // R3/R4/R5 priority and bookkeeping
    pulse(32'h0010_0000);
    ack(mk_vec(2, 0, 20), "R3 R4 vec20");
    rd(2'd2, d); check("R5 isr20", d, 32'h0010_0000);
    rd(2'd1, d); check("R5 pend cleared", d, 32'h20);
    check("R9 lower blocked", 32'(irq_o), 0);

    pulse(32'h0200_0000);
    check("R9 higher nests", 32'(irq_o), 1);
    ack(mk_vec(2, 0, 25), "R4 vec25");
    rd(2'd2, d); check("R5 isr nest", d, 32'h0210_0000);

    // R6 W1C
    wr(2'd2, 32'h0200_0000);
    rd(2'd2, d); check("R6 partial", d, 32'h0010_0000);
    check("R9 still blocked", 32'(irq_o), 0);
    wr(2'd2, 32'h0010_0000);
    rd(2'd2, d); check("R6 cleared", d, 32'h0);
    check("R9 unblocked", 32'(irq_o), 1);

    // R5 same-cycle event keeps pending
    ack(mk_vec(2, 0, 5), "R5 vec5", 32'h20);
    rd(2'd1, d); check("R5 repend", d, 32'h20);
    rd(2'd2, d); check("R5 isr5", d, 32'h20);

    // R8 error vector
    wr(2'd2, 32'h20);
    wr(2'd0, 32'h0);
    check("R8 no irq", 32'(irq_o), 0);
    ack(mk_vec(2, 1, 0), "R8 err vec");
    rd(2'd2, d); check("R8 isr kept", d, 32'h0);
    rd(2'd1, d); check("R8 pend kept", d, 32'h20);

    // R3 boundaries 31 and 0
    wr(2'd0, 32'h8000_0001);
    pulse(32'h8000_0001);
    ack(mk_vec(2, 0, 31), "R3 vec31");
    wr(2'd2, 32'h8000_0000);
    ack(mk_vec(2, 0, 0), "R3 vec0");
    rd(2'd2, d); check("R3 isr0", d, 32'h1);
    wr(2'd2, 32'h1);
    check("R2 idle", 32'(irq_o), 0);
    rd(2'd1, d); check("R1 pend final", d, 32'h20);

    repeat (3) @(negedge clk_i);
    check("R4 queue drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule